// File: doc/BRIEF.md
# Reversible Bit Scramble and Unscramble Unit

This unit takes a 32-bit word and, in one clock, either scrambles it or undoes a scramble. Scrambling sends every bit to a new position through a fixed permutation with no fixed points, then flips a fixed half of the result bits. Unscrambling first flips the same half and then applies the inverse permutation. Both paths are plain combinational networks. The result is captured in an output register, so a request on `in_valid` gives `out_valid` and `dout` one cycle later.

The pair can hide the content of a word, or spread a burst of adjacent bit errors across a word before error correction. Because each direction is a bijection and the two are exact inverses, feeding the output back as the next input walks a deterministic, seedable sequence of states. That walk can be run forward with the scramble and backward with the unscramble.

Top module: `bit_scrambler`

## Requirements
- R1: With `dir`=0 (scramble), output bit (13*i+7) mod 32 equals input bit i XOR mask bit (13*i+7) mod 32. Mask bit j is 1 exactly when j mod 4 is 1 or 2.
- R2: With `dir`=0 and an input holding a single set bit at position i, the moved bit lands at a position other than i.
- R3: Scrambling the all-zeros word gives a result with exactly 16 ones.
- R4: With `dir`=1 (unscramble), unscrambling a scrambled word returns the original word.
- R5: Scrambling an unscrambled word returns the original word.
- R6: A request accepted with `in_valid`=1 at a rising edge makes `out_valid` high and puts the result on `dout` right after that edge. `out_valid` is low after any edge that sees `in_valid`=0.
- R7: `dout` holds its last value across edges where `in_valid` is 0.
- R8: While `rst_n` is low, `out_valid` is 0 and `dout` is all zeros.
- R9: Stepping a seed forward N times with `dir`=0 and then N times with `dir`=1 returns the seed. Each forward step matches the R1 mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for the operand on `din` |
| dir | input | 1 | 0 scrambles, 1 unscrambles |
| din | input | 32 | Operand word |
| dout | output | 32 | Registered result |
| out_valid | output | 1 | High for the cycle after an accepted request |

## Verification
Every result is due exactly one rising edge after the request. The bench drives `in_valid`, `dir` and `din` at a falling edge and reads `dout` and `out_valid` at the next falling edge, which falls after the single register stage. Round trips chain two such requests and take the first result back as the next operand. The hold checks drop `in_valid` and read the outputs again at later falling edges. The bench computes expected words from the position formula and the mask rule of R1, sweeping all single-bit words, the all-zeros and all-ones words, and a pseudo-random set. The forward walk is stepped from a seed until the seed repeats or a step limit is reached, and is then walked back the same number of steps.

// File: rtl/scr_pkg.sv
package scr_pkg;

    parameter int DATA_W  = 32;
    parameter int PERM_MUL = 13;  // odd, so the map is a bijection for a power-of-two width
    parameter int PERM_ADD = 7;   // odd, so no position maps to itself

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  vld;
        word_t data;
    } out_state_t;

    function automatic int dst_pos(input int src);
        return (PERM_MUL * src + PERM_ADD) % DATA_W;
    endfunction

    function automatic word_t flip_mask();
        word_t m;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = ((j % 4) == 1) || ((j % 4) == 2);
        end
        return m;
    endfunction

endpackage

// File: rtl/scr_perm_net.sv
module scr_perm_net
    import scr_pkg::*;
#(
    parameter bit GATHER = 1'b0  // 0: scatter (forward), 1: gather (inverse)
) (
    input  word_t vec_i,
    output word_t vec_o
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        localparam int TGT = (PERM_MUL * i + PERM_ADD) % DATA_W;
        if (GATHER) begin : g_inv
            assign vec_o[i] = vec_i[TGT];
        end else begin : g_fwd
            assign vec_o[TGT] = vec_i[i];
        end
    end

endmodule

// File: rtl/scr_flip_stage.sv
module scr_flip_stage
    import scr_pkg::*;
(
    input  word_t vec_i,
    output word_t vec_o
);

    localparam word_t MASK = flip_mask();

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        if (MASK[j]) begin : g_flip
            assign vec_o[j] = ~vec_i[j];
        end else begin : g_pass
            assign vec_o[j] = vec_i[j];
        end
    end

endmodule

// File: rtl/bit_scrambler.sv
module bit_scrambler
    import scr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        dir,
    input  logic [31:0] din,
    output logic [31:0] dout,
    output logic        out_valid
);

    localparam word_t MASK = flip_mask();
    localparam int    HALF = DATA_W / 2;

    word_t fwd_perm, fwd_res;
    word_t rev_flip, rev_res;
    out_state_t st_d, st_q;

    // scramble: move, then flip
    scr_perm_net #(.GATHER(1'b0)) u_fwd_perm (.vec_i(din),      .vec_o(fwd_perm));
    scr_flip_stage                u_fwd_flip (.vec_i(fwd_perm), .vec_o(fwd_res));

    // unscramble: flip, then move back
    scr_flip_stage                u_rev_flip (.vec_i(din),      .vec_o(rev_flip));
    scr_perm_net #(.GATHER(1'b1)) u_rev_perm (.vec_i(rev_flip), .vec_o(rev_res));

    always_comb begin
        st_d = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = dir ? rev_res : fwd_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.data;
    assign out_valid = st_q.vld;

    // R6: valid follows the accepted request by one edge
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7: no request, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dout));

    // R1: scramble keeps the weight once the flipped half is taken back
    p_fwd_weight_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir) |=> ($countones(dout ^ MASK) == $past($countones(din))));

    // R4: unscramble result weight equals weight of operand with the half flipped
    p_rev_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir) |=> ($countones(dout) == $past($countones(din ^ MASK))));

    // R3: scrambled zero carries exactly half ones
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir && din == '0) |=> ($countones(dout) == HALF));

    // R8: reset clears the outputs
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && dout == '0));

endmodule

// File: tb/bit_scrambler_test.sv
`timescale 1ns/1ps
module bit_scrambler_test;

    localparam int W = 32;
    localparam int MUL = 13;
    localparam int ADD = 7;
    localparam int WALK_LIMIT = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic dir = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic out_valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit_scrambler uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir),
        .din(din), .dout(dout), .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_mask();
        logic [31:0] m;
        for (int j = 0; j < W; j++) m[j] = ((j % 4) == 1) || ((j % 4) == 2);
        return m;
    endfunction

    function automatic logic [31:0] ref_fwd(input logic [31:0] x);
        logic [31:0] y;
        y = '0;
        for (int i = 0; i < W; i++) y[(MUL * i + ADD) % W] = x[i];
        return y ^ ref_mask();
    endfunction

    function automatic logic [31:0] ref_rev(input logic [31:0] y);
        logic [31:0] t, x;
        t = y ^ ref_mask();
        x = '0;
        for (int i = 0; i < W; i++) x[i] = t[(MUL * i + ADD) % W];
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic d, input logic [31:0] x, output logic [31:0] r);
        in_valid = 1'b1;
        dir = d;
        din = x;
        @(negedge clk);
        check("R6 out_valid", {31'b0, out_valid}, 32'd1);
        r = dout;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2, x, seed, st, held;
        int steps;
        bit back;

        repeat (3) @(negedge clk);
        check("R8 out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R8 dout in reset", dout, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", {31'b0, out_valid}, 32'd0);

        // R3: zero word
        run_op(1'b0, 32'h0, r);
        check("R3 popcount", 32'($countones(r)), 32'd16);
        check("R1 zero", r, ref_fwd(32'h0));

        // R1/R4/R5 all-ones
        run_op(1'b0, 32'hFFFF_FFFF, r);
        check("R1 ones", r, ref_fwd(32'hFFFF_FFFF));
        run_op(1'b1, r, r2);
        check("R4 ones", r2, 32'hFFFF_FFFF);

        // R7: hold with in_valid low
        held = dout;
        din = 32'hDEAD_BEEF;
        dir = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 dout held", dout, held);
        check("R6 out_valid low", {31'b0, out_valid}, 32'd0);

        // single-bit sweep: R1, R2, R4, R5
        for (int i = 0; i < W; i++) begin
            x = 32'h1 << i;
            run_op(1'b0, x, r);
            check("R1 single", r, ref_fwd(x));
            checks++;
            if ((r ^ ref_mask()) == x) begin
                fails++;
                $display("FAIL R2 bit %0d: actual %h expected moved", i, r ^ ref_mask());
            end
            run_op(1'b1, r, r2);
            check("R4 single", r2, x);
            run_op(1'b1, x, r);
            check("R5 rev ref", r, ref_rev(x));
            run_op(1'b0, r, r2);
            check("R5 single", r2, x);
        end

        // pseudo-random words
        x = 32'h1234_5678;
        for (int k = 0; k < 200; k++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            run_op(1'b0, x, r);
            check("R1 random", r, ref_fwd(x));
            run_op(1'b1, r, r2);
            check("R4 random", r2, x);
            run_op(1'b1, x, r);
            run_op(1'b0, r, r2);
            check("R5 random", r2, x);
        end

        // R9: forward walk then backward walk
        seed = 32'hC0FF_EE01;
        st = seed;
        steps = 0;
        back = 1'b0;
        for (int k = 0; k < WALK_LIMIT; k++) begin
            run_op(1'b0, st, r);
            check("R9 step", r, ref_fwd(st));
            st = r;
            steps++;
            if (st == seed) begin
                back = 1'b1;
                break;
            end
        end
        if (back) $display("walk: seed repeated after %0d steps", steps);
        else $display("walk: no repeat within %0d steps", steps);
        for (int k = 0; k < steps; k++) begin
            run_op(1'b1, st, r);
            st = r;
        end
        check("R9 walk back", st, seed);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule